// File: doc/BRIEF.md
# Piecewise-Linear Luma Gamma Corrector

This block reshapes an 8-bit luma stream through a programmable transfer curve. The curve is defined on 256 input codes by fourteen knots. Ten knots sit at fixed, unevenly spaced input codes, and their output values are programmable. The remaining four knots are hard-wired to identity. Between two neighbouring knots the output is a straight-line interpolation. Input codes below 16, and codes from 240 up, therefore come out unchanged.

Two independent curves are held, bank A and bank B. A select input picks which bank shapes each sample, and an enable input bypasses the curve altogether. Knot values are loaded through a simple write port into a shadow copy. The shadow copy becomes the live curve only when a field boundary strobe arrives, so a curve never changes partway through a field. Samples travel on a valid/ready stream through two register stages.

Top module: `gamma_pwl`

## Requirements
- R1: After reset `valid_o` is low, and both banks hold the identity curve, so every enabled sample comes out equal to its input.
- R2: A sample accepted with `en_i` low comes out equal to its input code.
- R3: A sample accepted with `en_i` high and an input code below 16, or at or above 240, comes out equal to its input code.
- R4: For an enabled input x with 16 <= x < 240, the output is computed from the neighbouring knots (x0,y0) and (x1,y1) as y0 + floor((x-x0)*(y1-y0)/(x1-x0)). The knot input codes are 16, 24, 32, 48, 64, 80, 96, 128, 160, 192, 224 and 240. The knot at 16 has output 16, the knot at 240 has output 240, and the ten programmable knots take their live values.
- R5: `sel_i` sampled with the sample chooses the curve: 0 selects bank A, 1 selects bank B.
- R6: A write stores `wr_data_i` into the shadow knot `wr_idx_i` of bank `wr_bank_i` (0 = A, 1 = B). Indices 0 to 9 name the knots at 24, 32, 48, 64, 80, 96, 128, 160, 192 and 224, in ascending order. The live curve is unchanged until `field_strobe_i` is high on a clock edge, which copies both shadow banks to the live banks.
- R7: A write in the same cycle as the strobe does not reach the live curve at that strobe. It takes effect at the next strobe.
- R8: A write with `wr_idx_i` of 10 or more changes no knot.
- R9: With `ready_i` high, a sample accepted (`valid_i` and `ready_o` high) at one clock edge is presented with `valid_o` high after the next clock edge, and not before.
- R10: While `valid_o` is high and `ready_i` is low, `ready_o` is low, and `valid_o` and `data_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Curve enable, sampled with each sample |
| sel_i | input | 1 | Curve select, 0 = bank A, 1 = bank B |
| field_strobe_i | input | 1 | Field boundary strobe; commits the shadow banks |
| wr_en_i | input | 1 | Knot write enable |
| wr_bank_i | input | 1 | Write bank, 0 = A, 1 = B |
| wr_idx_i | input | 4 | Programmable knot index, 0 to 9 |
| wr_data_i | input | 8 | Knot output value |
| valid_i | input | 1 | Input sample valid |
| ready_o | output | 1 | Input sample accepted when high |
| data_i | input | 8 | Input luma code |
| valid_o | output | 1 | Output sample valid |
| ready_i | input | 1 | Downstream ready |
| data_o | output | 8 | Corrected luma code |

## Verification
All 256 input codes are swept through several curves:
- The reset identity curve.
- A rising, gamma-like curve, which exercises every segment width.
- A jagged curve with steep falling segments, which separates floor rounding from truncation toward zero.
- The same codes with the curve disabled.

Commit timing is probed with one code sampled at three points: before a strobe, after a strobe that coincides with a write, and after a later strobe. Out-of-range write indices are followed by a full sweep to show no knot moved. A stalled output is held against a low `ready_i` to check that the output holds and the cycle count of the latency.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int DW     = 8;
  localparam int NPROG  = 10;
  localparam int NKNOT  = NPROG + 4;
  localparam int IW     = $clog2(NPROG);
  localparam int DXW    = 6;
  localparam int SHW    = 3;

  // input code of knot j; knots 2..11 are programmable
  function automatic int knot_pos(input int j);
    case (j)
      0: return 0;    1: return 16;   2: return 24;   3: return 32;
      4: return 48;   5: return 64;   6: return 80;   7: return 96;
      8: return 128;  9: return 160;  10: return 192; 11: return 224;
      12: return 240;
      default: return 255;
    endcase
  endfunction

  function automatic int seg_log2(input int j);
    return $clog2(knot_pos(j + 1) - knot_pos(j));
  endfunction
endpackage

// File: rtl/gamma_bank_regs.sv
module gamma_bank_regs
  import gamma_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      wr_bank_i,
  input  logic [IW-1:0]             wr_idx_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic                      commit_i,
  input  logic                      sel_i,
  output logic [NPROG-1:0][DW-1:0]  pts_o
);
  logic [1:0][NPROG-1:0][DW-1:0] shd_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < NPROG; k++) begin
          shd_q[b][k] <= DW'(knot_pos(k + 2));
          act_q[b][k] <= DW'(knot_pos(k + 2));
        end
    end else begin
      // commit sees the shadow as it was before this edge's write
      if (commit_i) act_q <= shd_q;
      if (wr_en_i && (int'(wr_idx_i) < NPROG))
        shd_q[wr_bank_i][wr_idx_i] <= wr_data_i;
    end
  end

  assign pts_o = act_q[sel_i];
endmodule

// File: rtl/gamma_seg_find.sv
module gamma_seg_find
  import gamma_pkg::*;
(
  input  logic [DW-1:0]             x_i,
  input  logic                      en_i,
  input  logic [NPROG-1:0][DW-1:0]  pts_i,
  output logic                      pass_o,
  output logic [DXW-1:0]            dx_o,
  output logic [DW-1:0]             y0_o,
  output logic [DW-1:0]             y1_o,
  output logic [SHW-1:0]            sh_o
);
  logic [NKNOT-1:0][DW-1:0] ky;
  logic [3:0]               seg;
  logic [DW-1:0]            base;

  for (genvar j = 0; j < NKNOT; j++) begin : g_knot
    if (j >= 2 && j < NPROG + 2) begin : g_prog
      assign ky[j] = pts_i[j-2];
    end else begin : g_fix
      assign ky[j] = DW'(knot_pos(j));
    end
  end

  always_comb begin
    seg  = '0;
    base = '0;
    sh_o = '0;
    for (int j = 1; j <= NKNOT - 2; j++) begin
      if (int'(x_i) >= knot_pos(j)) begin
        seg  = 4'(j);
        base = DW'(knot_pos(j));
        sh_o = SHW'(seg_log2(j));
      end
    end
  end

  assign pass_o = !en_i || (seg == 4'd0) || (seg == 4'(NKNOT - 2));
  assign dx_o   = DXW'(x_i - base);
  assign y0_o   = ky[seg];
  assign y1_o   = ky[seg + 4'd1];
endmodule

// File: rtl/gamma_lerp.sv
module gamma_lerp
  import gamma_pkg::*;
(
  input  logic            pass_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DXW-1:0]  dx_i,
  input  logic [DW-1:0]   y0_i,
  input  logic [DW-1:0]   y1_i,
  input  logic [SHW-1:0]  sh_i,
  output logic [DW-1:0]   y_o
);
  logic signed [DW:0]  d;
  logic signed [15:0]  dxs, ds, prod, q, sum;

  assign d    = $signed({1'b0, y1_i}) - $signed({1'b0, y0_i});
  assign dxs  = $signed({{(16-DXW){1'b0}}, dx_i});
  assign ds   = $signed({{(15-DW){d[DW]}}, d});
  assign prod = dxs * ds;
  assign q    = prod >>> sh_i;   // arithmetic shift floors
  assign sum  = $signed({{(16-DW){1'b0}}, y0_i}) + q;
  assign y_o  = pass_i ? x_i : sum[DW-1:0];
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl
  import gamma_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            sel_i,
  input  logic            field_strobe_i,
  input  logic            wr_en_i,
  input  logic            wr_bank_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            valid_i,
  output logic            ready_o,
  input  logic [DW-1:0]   data_i,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [DW-1:0]   data_o
);
  logic [NPROG-1:0][DW-1:0] pts;
  logic                     adv;

  logic            f_pass;
  logic [DXW-1:0]  f_dx;
  logic [DW-1:0]   f_y0, f_y1;
  logic [SHW-1:0]  f_sh;

  logic            s1_v, s1_pass;
  logic [DW-1:0]   s1_x, s1_y0, s1_y1;
  logic [DXW-1:0]  s1_dx;
  logic [SHW-1:0]  s1_sh;
  logic [DW-1:0]   l_y;

  logic            out_v;
  logic [DW-1:0]   out_d;

  gamma_bank_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_bank_i, .wr_idx_i, .wr_data_i,
    .commit_i(field_strobe_i), .sel_i, .pts_o(pts)
  );

  gamma_seg_find u_find (
    .x_i(data_i), .en_i, .pts_i(pts), .pass_o(f_pass), .dx_o(f_dx),
    .y0_o(f_y0), .y1_o(f_y1), .sh_o(f_sh)
  );

  gamma_lerp u_lerp (
    .pass_i(s1_pass), .x_i(s1_x), .dx_i(s1_dx), .y0_i(s1_y0),
    .y1_i(s1_y1), .sh_i(s1_sh), .y_o(l_y)
  );

  assign adv     = ready_i || !out_v;
  assign ready_o = adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v    <= 1'b0;
      s1_pass <= 1'b1;
      s1_x    <= '0;
      s1_dx   <= '0;
      s1_y0   <= '0;
      s1_y1   <= '0;
      s1_sh   <= '0;
      out_v   <= 1'b0;
      out_d   <= '0;
    end else if (adv) begin
      s1_v  <= valid_i;
      out_v <= s1_v;
      if (valid_i) begin
        s1_pass <= f_pass;
        s1_x    <= data_i;
        s1_dx   <= f_dx;
        s1_y0   <= f_y0;
        s1_y1   <= f_y1;
        s1_sh   <= f_sh;
      end
      if (s1_v) out_d <= l_y;
    end
  end

  assign valid_o = out_v;
  assign data_o  = out_d;
endmodule

// File: rtl/gamma_pwl_chk.sv
module gamma_pwl_chk
  import gamma_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          valid_i,
  input logic          ready_o,
  input logic [DW-1:0] data_i,
  input logic          valid_o,
  input logic          ready_i,
  input logic [DW-1:0] data_o
);
  assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !valid_o);

  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(ready_i) && $past(valid_i && ready_o && !en_i, 2))
    |-> (data_o == $past(data_i, 2)));

  assert_fixed_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(ready_i) &&
     $past(valid_i && ready_o && en_i && (data_i < 8'd16 || data_i >= 8'd240), 2))
    |-> (data_o == $past(data_i, 2)));

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(ready_i) && $past(valid_i && ready_o, 2)) |-> valid_o);

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_o && !ready_i) |-> (valid_o && $stable(data_o)));

  assert_stall_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |-> !ready_o);
endmodule

bind gamma_pwl gamma_pwl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
  .ready_o(ready_o), .data_i(data_i), .valid_o(valid_o),
  .ready_i(ready_i), .data_o(data_o)
);

// File: tb/sim_gamma_pwl.sv
module sim_gamma_pwl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1, sel_i = 1'b0, field_strobe_i = 1'b0;
  logic       wr_en_i = 1'b0, wr_bank_i = 1'b0;
  logic [3:0] wr_idx_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       valid_i = 1'b0, ready_i = 1'b1;
  logic [7:0] data_i = '0;
  logic       ready_o, valid_o;
  logic [7:0] data_o;

  int n_chk = 0, n_fail = 0;
  int shA[10], shB[10], acA[10], acB[10];
  int kp[14] = '{0, 16, 24, 32, 48, 64, 80, 96, 128, 160, 192, 224, 240, 255};

  always #5 clk_i = ~clk_i;

  gamma_pwl u0 (.*);

  function automatic int gold(int x, bit en, bit sel);
    int ky[14];
    int j, w, d, prod, q;
    if (!en || x < 16 || x >= 240) return x;
    for (int k = 0; k < 14; k++)
      ky[k] = (k >= 2 && k <= 11) ? (sel ? acB[k-2] : acA[k-2]) : kp[k];
    j = 1;
    while (x >= kp[j+1]) j++;
    w = kp[j+1] - kp[j];
    d = ky[j+1] - ky[j];
    prod = (x - kp[j]) * d;
    q = (prod >= 0) ? prod / w : -((-prod + w - 1) / w);
    return ky[j] + q;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit bank, int idx, int val, bit strobe);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_bank_i = bank; wr_idx_i = 4'(idx); wr_data_i = 8'(val);
    field_strobe_i = strobe;
    @(negedge clk_i);
    wr_en_i = 1'b0; field_strobe_i = 1'b0;
    if (strobe) begin acA = shA; acB = shB; end
    if (idx < 10) begin
      if (bank) shB[idx] = val; else shA[idx] = val;
    end
  endtask

  task automatic strobe();
    @(negedge clk_i);
    field_strobe_i = 1'b1;
    @(negedge clk_i);
    field_strobe_i = 1'b0;
    acA = shA; acB = shB;
  endtask

  task automatic sample(string req, int x, bit en, bit sel);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 8'(x); en_i = en; sel_i = sel;
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    check({req, " valid"}, int'(valid_o), 1);
    check({req, " data"}, int'(data_o), gold(x, en, sel));
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a_vals[10] = '{40, 52, 74, 94, 112, 128, 158, 185, 210, 228};
    int b_vals[10] = '{10, 5, 200, 30, 0, 255, 100, 60, 20, 250};
    for (int k = 0; k < 10; k++) begin
      shA[k] = kp[k+2]; shB[k] = kp[k+2];
    end
    acA = shA; acB = shB;
    repeat (3) @(negedge clk_i);
    check("R1 reset valid_o", int'(valid_o), 0);
    check("R1 reset ready_o", int'(ready_o), 1);
    rst_ni = 1'b1;
    // R1: identity curve on both banks
    for (int x = 0; x < 256; x++) sample("R1", x, 1'b1, x[0]);
    // R6: writes land in shadow only
    for (int k = 0; k < 10; k++) wr(1'b0, k, a_vals[k], 1'b0);
    for (int k = 0; k < 10; k++) wr(1'b1, k, b_vals[k], 1'b0);
    sample("R6 pre-strobe", 100, 1'b1, 1'b0);
    sample("R6 pre-strobe", 200, 1'b1, 1'b1);
    strobe();
    // R3/R4: bank A full sweep; R5: bank B full sweep
    for (int x = 0; x < 256; x++) sample("R4 bankA", x, 1'b1, 1'b0);
    for (int x = 0; x < 256; x++) sample("R5 bankB", x, 1'b1, 1'b1);
    for (int x = 0; x < 256; x += 3) sample("R3 ends", x < 16 ? x : 240 + (x % 16), 1'b1, 1'b1);
    // R2: disabled
    for (int x = 0; x < 256; x++) sample("R2 bypass", x, 1'b0, x[1]);
    // R8: out-of-range index
    for (int k = 10; k < 16; k++) wr(k[0], k, 8'h77, 1'b0);
    strobe();
    for (int x = 0; x < 256; x++) sample("R8 bankA", x, 1'b1, 1'b0);
    for (int x = 0; x < 256; x++) sample("R8 bankB", x, 1'b1, 1'b1);
    // R7: write coinciding with strobe waits for next strobe
    wr(1'b0, 0, 200, 1'b1);
    sample("R7 same-cycle", 24, 1'b1, 1'b0);
    check("R7 old value kept", int'(data_o), 40);
    strobe();
    sample("R7 next strobe", 24, 1'b1, 1'b0);
    check("R7 new value", int'(data_o), 200);
    // R9/R10: latency and stall
    @(negedge clk_i);
    ready_i = 1'b0; valid_i = 1'b1; data_i = 8'd100; en_i = 1'b1; sel_i = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R9 not yet valid", int'(valid_o), 0);
    @(negedge clk_i);
    check("R9 valid after two edges", int'(valid_o), 1);
    check("R9 data", int'(data_o), gold(100, 1'b1, 1'b0));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i);
      check("R10 held valid", int'(valid_o), 1);
      check("R10 held data", int'(data_o), gold(100, 1'b1, 1'b0));
      check("R10 ready_o low", int'(ready_o), 0);
    end
    ready_i = 1'b1;
    @(negedge clk_i);
    check("R10 drained", int'(valid_o), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule